// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a software-driven SPI master that executes exactly one flash command per launch. Software first loads three things through a simple register port: an eight-entry table of command opcodes, a 24-bit flash address and, for commands that carry data, a 64-byte data buffer. It then writes a 16-bit control word. That word picks an opcode from the table, sets how many data bytes move, says whether a data phase happens at all, and sets a start bit. The block shifts out the opcode and the three address bytes, MSB first, in SPI mode 0. If the chosen table entry is marked as a write, the data bytes come out of the buffer. If it is marked as a read, the bytes clocked in from the flash are stored into the buffer.

For commands that need an enabling command first, the control word can request an atomic pair. In that case one of two stored prefix opcodes goes out as its own chip-select transaction. The selected command follows it straight away, and the block never returns to idle in between. When the command completes, a sticky done flag is raised. That flag can drive a request line, and software clears it by writing a 1.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset the control register reads 16'h4005, the status register reads 0, spi_cs_n is high, spi_sck is low and irq is low.
- R2: Register map: 0 control, 1 status (bit 0 busy, bit 1 done), 2 address bits 15:0, 3 address bits 23:16, 4 prefix opcodes (low byte = prefix 0, high byte = prefix 1), 8 to 15 opcode table entries (bits 7:0 opcode, bit 8 set = write type), 64 to 127 data buffer bytes 0 to 63. Writing the control register with bit 1 (start) set launches a cycle that uses the other fields of that same write, and sets busy. Bit 1 always reads back as 0.
- R3: Control fields: bit 15 done request enable, bit 14 data phase enable, bits 13:8 byte count, bit 7 reserved (reads 0), bits 6:4 table pointer, bit 3 prefix pointer, bit 2 atomic enable, bit 0 access flag (stored only). Each transaction is SPI mode 0: SCK idles low, MOSI is sent MSB first, and the sequence is the table opcode followed by the address bytes 23:16, 15:8, 7:0.
- R4: With the data phase enabled, the number of data bytes equals the byte count plus 1, so a count of 0 moves 1 byte and a count of 63 moves 64 bytes.
- R5: With the data phase disabled, the transaction ends after the third address byte, whatever the byte count holds.
- R6: A write-type entry sends buffer bytes starting at byte 0. A read-type entry stores each received byte into the buffer starting at byte 0, sends 0 on MOSI, and leaves buffer bytes beyond the count untouched.
- R7: With atomic enable set, the prefix opcode picked by the prefix pointer (0 = low byte, 1 = high byte) is sent first as a one-byte chip-select transaction. The command transaction follows it, and busy stays high from the launch to the end of the command.
- R8: A control write while busy is ignored entirely: no new cycle starts and the control register keeps its value.
- R9: At the end of the command, busy clears and done sets. Done stays set until a write to status with bit 1 set. Writing 0 to that bit has no effect.
- R10: irq is high exactly when done is 1 and the request enable (control bit 15) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (see R2) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in, sampled on the SCK rising edge |
| irq | output | 1 | Done request |

## Verification
The bench builds the block with CLK_DIV set to 2, so each SCK half-period lasts two clocks. At that setting the longest cycle, an opcode plus three address bytes plus 64 data bytes, finishes in a little over two thousand clocks. The full 1 to 64 byte range, both prefix pointer values and a lockout attempt in the middle of a long read all fit easily within the run. A slave model inside the bench records each chip-select transaction byte by byte and answers reads with a known pattern. The buffer contents and transaction lengths can then be compared against that pattern.

// File: rtl/spi_flash_seq.sv
`timescale 1ns/1ps
module spi_flash_seq #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        irq
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LOAD = DW'(CLK_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;

  state_t      state;
  logic [15:0] ctrl;
  logic        busy, done;
  logic [23:0] faddr;
  logic [15:0] pfx;
  logic [8:0]  menu [8];
  logic [7:0]  dbuf [64];
  logic        in_pfx, phase, sck_q;
  logic [6:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic [DW-1:0] div_cnt;
  logic [7:0]  rx;

  logic [8:0]  entry;
  logic [7:0]  pfx_op, tx_byte;
  logic [6:0]  last_idx;
  logic [5:0]  data_idx;
  logic        tick, ctrl_wr, go, byte_end, spi_buf_we;

  assign entry    = menu[ctrl[6:4]];
  assign pfx_op   = ctrl[3] ? pfx[15:8] : pfx[7:0];
  assign last_idx = in_pfx ? 7'd0 : (ctrl[14] ? 7'd4 + {1'b0, ctrl[13:8]} : 7'd3);
  assign data_idx = byte_idx[5:0] - 6'd4;
  assign tick     = (div_cnt == '0);
  assign ctrl_wr  = reg_we && (reg_addr == 7'd0) && !busy;
  assign go       = ctrl_wr && reg_wdata[1];
  assign byte_end = (state == S_XFER) && tick && phase && (bit_idx == 3'd7);
  assign spi_buf_we = byte_end && !in_pfx && (byte_idx >= 7'd4) && !entry[8];

  always_comb begin
    if (in_pfx)                 tx_byte = pfx_op;
    else if (byte_idx == 7'd0)  tx_byte = entry[7:0];
    else if (byte_idx == 7'd1)  tx_byte = faddr[23:16];
    else if (byte_idx == 7'd2)  tx_byte = faddr[15:8];
    else if (byte_idx == 7'd3)  tx_byte = faddr[7:0];
    else if (entry[8])          tx_byte = dbuf[data_idx];
    else                        tx_byte = 8'h00;
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = (state != S_XFER);
  assign spi_mosi = (state == S_XFER) ? tx_byte[3'd7 - bit_idx] : 1'b0;
  assign irq      = done && ctrl[15];

  always_comb begin
    reg_rdata = 16'h0000;
    if (reg_addr[6])
      reg_rdata = {8'h00, dbuf[reg_addr[5:0]]};
    else if (reg_addr[5:3] == 3'b001)
      reg_rdata = {7'h00, menu[reg_addr[2:0]]};
    else
      case (reg_addr[2:0])
        3'd0: reg_rdata = ctrl;
        3'd1: reg_rdata = {14'h0000, done, busy};
        3'd2: reg_rdata = faddr[15:0];
        3'd3: reg_rdata = {8'h00, faddr[23:16]};
        3'd4: reg_rdata = pfx;
        default: reg_rdata = 16'h0000;
      endcase
  end

  always_ff @(posedge clk) begin
    if (reg_we && reg_addr[6])
      dbuf[reg_addr[5:0]] <= reg_wdata[7:0];
    else if (spi_buf_we)
      dbuf[data_idx] <= rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ctrl     <= 16'h4005;
      busy     <= 1'b0;
      done     <= 1'b0;
      faddr    <= '0;
      pfx      <= '0;
      for (int i = 0; i < 8; i++) menu[i] <= '0;
      in_pfx   <= 1'b0;
      phase    <= 1'b0;
      sck_q    <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      div_cnt  <= '0;
      rx       <= '0;
    end else begin
      if (reg_we && !reg_addr[6]) begin
        if (reg_addr[5:3] == 3'b001) menu[reg_addr[2:0]] <= reg_wdata[8:0];
        else
          case (reg_addr[2:0])
            3'd1: if (reg_wdata[1]) done <= 1'b0;
            3'd2: faddr[15:0]  <= reg_wdata;
            3'd3: faddr[23:16] <= reg_wdata[7:0];
            3'd4: pfx <= reg_wdata;
            default: ;
          endcase
      end
      if (ctrl_wr) ctrl <= reg_wdata & 16'hFF7D;
      if (go) begin
        busy     <= 1'b1;
        state    <= S_XFER;
        in_pfx   <= reg_wdata[2];
        byte_idx <= '0;
        bit_idx  <= '0;
        phase    <= 1'b0;
        sck_q    <= 1'b0;
        div_cnt  <= DIV_LOAD;
      end else if (state != S_IDLE) begin
        if (!tick) div_cnt <= div_cnt - 1'b1;
        else begin
          div_cnt <= DIV_LOAD;
          if (state == S_GAP) begin
            in_pfx   <= 1'b0;
            byte_idx <= '0;
            state    <= S_XFER;
          end else if (!phase) begin
            sck_q <= 1'b1;
            rx    <= {rx[6:0], spi_miso};
            phase <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            phase <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              if (byte_idx != last_idx) byte_idx <= byte_idx + 1'b1;
              else if (in_pfx) state <= S_GAP;
              else begin
                state <= S_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_seq_chk.sv
`timescale 1ns/1ps
module spi_flash_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [6:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic [15:0] ctrl,
  input logic        busy,
  input logic        done,
  input logic        spi_sck,
  input logic        spi_cs_n,
  input logic        irq
);
  // R3
  mode0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R2
  go_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 7'd0) |-> !reg_rdata[1]);
  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 7'd0 && busy) |=> $stable(ctrl));
  // R9
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  // R10
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ctrl[15]));
endmodule

bind spi_flash_seq spi_flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ctrl(ctrl), .busy(busy), .done(done),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .irq(irq)
);

// File: tb/spi_flash_seq_test.sv
`timescale 1ns/1ps
module spi_flash_seq_test;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [6:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_flash_seq #(.CLK_DIV(2)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq));

  function automatic logic [7:0] resp(int k);
    return 8'(k * 29) ^ 8'hA5;
  endfunction

  int cur_len = 0, bitc = 0, tot = 0, ntx = 0;
  logic [7:0] sh = 0, cur_resp = 0;
  logic [7:0] lg [0:255];
  int tl [0:7];
  assign spi_miso = cur_resp[3'd7 - bitc[2:0]];

  always @(negedge spi_cs_n) begin cur_len = 0; bitc = 0; cur_resp = resp(0); end
  always @(posedge spi_sck) begin
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (tot < 256) lg[tot] = sh;
      tot++; cur_len++; bitc = 0;
    end
    cur_resp = resp(cur_len);
  end
  always @(posedge spi_cs_n) begin
    if (ntx < 8) tl[ntx] = cur_len;
    ntx++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [15:0] mk(bit ie, bit de, int cnt, int ptr, bit pp, bit at);
    return {ie, de, 6'(cnt), 1'b0, 3'(ptr), pp, at, 1'b1, 1'b0};
  endfunction

  task automatic clear_log(); ntx = 0; tot = 0; endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(7'd1, s);
      if (!s[0]) return;
    end
  endtask

  task automatic run(logic [15:0] c);
    wr(7'd1, 16'h0002);
    clear_log();
    wr(7'd0, c);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(7'd0, v); check(v == 16'h4005, "R1 ctrl", v, 16'h4005);
    rd(7'd1, v); check(v == 0, "R1 status", v, 0);
    check(spi_cs_n && !spi_sck && !irq, "R1 pins", {spi_cs_n, spi_sck, irq}, 3'b100);
  endtask

  task automatic t_write();
    logic [15:0] v;
    logic [7:0] exp [8];
    for (int i = 0; i < 4; i++) wr(7'(64 + i), 16'(8'hC0 + i));
    wr(7'd1, 16'h0002); clear_log();
    wr(7'd0, mk(0, 1, 3, 2, 0, 0));
    rd(7'd1, v); check(v[0] == 1, "R2 busy after start", v, 1);
    rd(7'd0, v); check(v[1] == 0, "R2 start bit reads 0", v[1], 0);
    wait_idle();
    rd(7'd1, v); check(v == 16'h0002, "R9 done set busy clear", v, 2);
    check(ntx == 1 && tl[0] == 8, "R4 write length", tl[0], 8);
    exp = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hC0, 8'hC1, 8'hC2, 8'hC3};
    for (int i = 0; i < 8; i++)
      check(lg[i] == exp[i], "R3 R6 write byte order", lg[i], exp[i]);
  endtask

  task automatic t_read();
    logic [15:0] v;
    wr(7'd65, 16'h0077);
    run(mk(0, 1, 0, 3, 0, 0));
    check(tl[0] == 5 && lg[0] == 8'h03, "R4 one byte read", tl[0], 5);
    check(lg[4] == 8'h00, "R6 read sends zero", lg[4], 0);
    rd(7'd64, v); check(v == {8'h00, resp(4)}, "R6 read stored", v, resp(4));
    rd(7'd65, v); check(v == 16'h0077, "R6 beyond count untouched", v, 16'h77);
    run(mk(0, 1, 63, 3, 0, 0));
    check(tl[0] == 68, "R4 64 byte read", tl[0], 68);
    rd(7'd127, v); check(v == {8'h00, resp(67)}, "R4 last byte stored", v, resp(67));
    rd(7'd96, v); check(v == {8'h00, resp(36)}, "R6 middle byte", v, resp(36));
  endtask

  task automatic t_nodata();
    run(mk(0, 0, 5, 2, 0, 0));
    check(ntx == 1 && tl[0] == 4, "R5 no data phase", tl[0], 4);
  endtask

  task automatic t_atomic();
    run(mk(0, 1, 1, 3, 1, 1));
    check(ntx == 2, "R7 two transactions", ntx, 2);
    check(tl[0] == 1 && lg[0] == 8'h50, "R7 prefix high byte", lg[0], 8'h50);
    check(tl[1] == 6 && lg[1] == 8'h03, "R7 command after prefix", lg[1], 3);
    run(mk(0, 1, 0, 2, 0, 1));
    check(tl[0] == 1 && lg[0] == 8'h06, "R7 prefix low byte", lg[0], 8'h06);
    check(tl[1] == 5 && lg[1] == 8'h02, "R7 second command", lg[1], 2);
  endtask

  task automatic t_lockout();
    logic [15:0] v, c;
    c = mk(0, 1, 63, 3, 0, 0);
    wr(7'd1, 16'h0002); clear_log();
    wr(7'd0, c);
    repeat (20) @(negedge clk);
    wr(7'd0, mk(1, 0, 0, 5, 1, 1));
    rd(7'd0, v); check(v == (c & 16'hFFFD), "R8 ctrl kept", v, c & 16'hFFFD);
    wait_idle();
    repeat (10) @(negedge clk);
    check(ntx == 1 && tl[0] == 68 && lg[0] == 8'h03, "R8 no restart", ntx, 1);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    check(irq == 0, "R10 irq off when disabled", irq, 0);
    wr(7'd1, 16'h0000);
    rd(7'd1, v); check(v[1] == 1, "R9 writing 0 keeps done", v, 2);
    wr(7'd1, 16'h0002);
    rd(7'd1, v); check(v[1] == 0, "R9 done cleared", v, 0);
    run(mk(1, 0, 0, 2, 0, 0));
    check(irq == 1, "R10 irq with done", irq, 1);
    wr(7'd1, 16'h0002);
    check(irq == 0, "R10 irq after clear", irq, 0);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    wr(7'd10, 16'h0102);
    wr(7'd11, 16'h0003);
    wr(7'd13, 16'h0005);
    wr(7'd2, 16'h3456);
    wr(7'd3, 16'h0012);
    wr(7'd4, 16'h5006);
    t_write();
    t_read();
    t_nodata();
    t_atomic();
    t_lockout();
    t_irq();
    finish_run();
  end
endmodule